// File: doc/BRIEF.md
# Fixed-Point Fractional Time Counter

This block keeps a 64-bit system time that is not a plain nanosecond count but a scaled fixed-point value. On every cycle of the reference clock it adds a runtime-programmable increment. Software picks the increment and the position of the binary point, and it turns the time into nanoseconds with a right shift. For example, an increment of 0x66666666 at a 6.4 ns reference period puts the binary point at bit 28. Changing the increment by small amounts trims the clock frequency.

A small register interface gives access to the two 32-bit time words and to the increment. Reading the low word captures the high word in a shadow register, so a low-then-high read pair returns one consistent 64-bit value even if a carry crosses the word boundary between the two reads. The increment register has two layouts, chosen by a mode input:

- **Wide layout:** a 31-bit increment.
- **Narrow layout:** a 24-bit increment, plus a period field above it that must hold 1 for the increment to be applied.

The full time value is also brought out as a snapshot bus for neighbouring blocks.

Top module: `systime_accum`

## Requirements
- R1: The active-low asynchronous reset clears both the time and the increment register. After reset the time stays at zero until an increment is written.
- R2: On each clock cycle in which no time word is written, the time advances by the effective increment, modulo 2^64.
- R3: In wide mode (`narrow_mode_i`=0) the effective increment is bits 30:0 of the increment register, and bit 31 is ignored.
- R4: In narrow mode (`narrow_mode_i`=1) the effective increment is bits 23:0 when bits 31:24 equal 1. For any other value of bits 31:24 the increment is zero and the time holds.
- R5: Register addresses are: 0 for the low time word, 1 for the high time word (read returns the shadow), 2 for the increment, and 3 reserved. Address 3 reads zero, and writes to it change nothing. Read data is combinational from the address.
- R6: A read of address 0 captures the current high time word into the shadow. A later read of address 1 returns that captured value, even if the time has since carried into the high word.
- R7: A write to address 0 or 1 replaces that time word at the next edge, leaves the other word unchanged, and suppresses the increment for that cycle. Counting resumes from the loaded value.
- R8: A write to the increment register is readable back in full. The cycle of the write still adds the old increment, and the new one applies from the next cycle.
- R9: A carry out of the low word propagates into the high word, and the top of the range wraps to zero.
- R10: The mode input selects the increment layout combinationally, so a mode change takes effect in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock; one tick per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| narrow_mode_i | input | 1 | 0: wide increment layout, 1: narrow layout with period field |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (side effect on address 0) |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data |
| time_o | output | 64 | Snapshot of the 64-bit time |

## Verification
The hardest case to reach is a carry rippling into the high word between the two halves of a read pair, because the time must sit just below a word boundary at the instant the low word is read. The bench gets there deterministically:

1. It loads both time words directly, just under the boundary.
2. It reads the low word in the very next cycle, so the carry lands before the high-word read.
3. It compares the shadowed high word against the already-advanced live value.

Wrap at 2^64, the gated narrow period field and an increment change in mid-count are reached the same way, by loading exact start values.

// File: rtl/systime_pkg.sv
package systime_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_TIME_LO = 2'd0,
    ADDR_TIME_HI = 2'd1,
    ADDR_INC     = 2'd2,
    ADDR_RSVD    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/systime_inc_decode.sv
module systime_inc_decode #(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned TIME_W       = 64,
  parameter int unsigned WIDE_INC_W   = 31,
  parameter int unsigned NARROW_INC_W = 24
) (
  input  logic [DATA_W-1:0] inc_reg_i,
  input  logic              narrow_i,
  output logic [TIME_W-1:0] inc_eff_o
);
  localparam int unsigned PERIOD_W = DATA_W - NARROW_INC_W;

  logic [PERIOD_W-1:0] period;
  logic [TIME_W-1:0]   wide_eff;
  logic [TIME_W-1:0]   narrow_eff;

  assign period   = inc_reg_i[DATA_W-1:NARROW_INC_W];
  assign wide_eff = {{(TIME_W-WIDE_INC_W){1'b0}}, inc_reg_i[WIDE_INC_W-1:0]};

  // narrow layout only advances when the period field is exactly one
  assign narrow_eff = (period == PERIOD_W'(1))
                    ? {{(TIME_W-NARROW_INC_W){1'b0}}, inc_reg_i[NARROW_INC_W-1:0]}
                    : '0;

  assign inc_eff_o = narrow_i ? narrow_eff : wide_eff;
endmodule

// File: rtl/systime_core.sv
module systime_core #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NWORDS = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [NWORDS-1:0]        word_wr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [DATA_W*NWORDS-1:0] inc_i,
  output logic [DATA_W*NWORDS-1:0] time_o
);
  localparam int unsigned TIME_W = DATA_W * NWORDS;

  logic [TIME_W-1:0] time_q;
  logic [TIME_W-1:0] time_d;
  logic [TIME_W-1:0] sum;
  logic              any_wr;

  assign sum    = time_q + inc_i;
  assign any_wr = |word_wr_i;

  // word load wins over the tick; unwritten words hold during a load
  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign time_d[w*DATA_W +: DATA_W] =
      word_wr_i[w] ? wdata_i :
      any_wr       ? time_q[w*DATA_W +: DATA_W] :
                     sum[w*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= '0;
    else         time_q <= time_d;
  end

  assign time_o = time_q;
endmodule

// File: rtl/systime_regif.sv
module systime_regif
  import systime_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  input  logic [2*DATA_W-1:0] time_i,
  output logic [DATA_W-1:0]   inc_q_o,
  output logic [DATA_W-1:0]   shadow_o,
  output logic [1:0]          word_wr_o,
  output logic [DATA_W-1:0]   reg_rdata_o
);
  reg_addr_e         addr;
  logic [DATA_W-1:0] inc_q;
  logic [DATA_W-1:0] shadow_q;

  assign addr = reg_addr_e'(reg_addr_i);

  assign word_wr_o[0] = reg_wr_i && (addr == ADDR_TIME_LO);
  assign word_wr_o[1] = reg_wr_i && (addr == ADDR_TIME_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inc_q <= '0;
    end else if (reg_wr_i && addr == ADDR_INC) begin
      inc_q <= reg_wdata_i;
    end
  end

  // low-word read freezes the upper half for the paired read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (reg_rd_i && addr == ADDR_TIME_LO) begin
      shadow_q <= time_i[2*DATA_W-1:DATA_W];
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_TIME_LO: reg_rdata_o = time_i[DATA_W-1:0];
      ADDR_TIME_HI: reg_rdata_o = shadow_q;
      ADDR_INC:     reg_rdata_o = inc_q;
      default:      reg_rdata_o = '0;
    endcase
  end

  assign inc_q_o  = inc_q;
  assign shadow_o = shadow_q;
endmodule

// File: rtl/systime_accum.sv
module systime_accum
  import systime_pkg::*;
#(
  parameter int unsigned WIDE_INC_W   = 31,
  parameter int unsigned NARROW_INC_W = 24
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                narrow_mode_i,
  input  logic                reg_wr_i,
  input  logic                reg_rd_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic [2*DATA_W-1:0] time_o
);
  localparam int unsigned NWORDS = 2;
  localparam int unsigned TIME_W = DATA_W * NWORDS;

  logic [DATA_W-1:0] inc_q;
  logic [DATA_W-1:0] shadow_q;
  logic [NWORDS-1:0] word_wr;
  logic [TIME_W-1:0] inc_eff;
  logic [TIME_W-1:0] time_q;

  systime_regif #(.DATA_W(DATA_W)) u_regif (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .time_i      (time_q),
    .inc_q_o     (inc_q),
    .shadow_o    (shadow_q),
    .word_wr_o   (word_wr),
    .reg_rdata_o (reg_rdata_o)
  );

  systime_inc_decode #(
    .DATA_W       (DATA_W),
    .TIME_W       (TIME_W),
    .WIDE_INC_W   (WIDE_INC_W),
    .NARROW_INC_W (NARROW_INC_W)
  ) u_dec (
    .inc_reg_i (inc_q),
    .narrow_i  (narrow_mode_i),
    .inc_eff_o (inc_eff)
  );

  systime_core #(.DATA_W(DATA_W), .NWORDS(NWORDS)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .word_wr_i (word_wr),
    .wdata_i   (reg_wdata_i),
    .inc_i     (inc_eff),
    .time_o    (time_q)
  );

  assign time_o = time_q;
endmodule

// File: rtl/systime_accum_chk.sv
module systime_accum_chk
  import systime_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                narrow_mode_i,
  input logic                reg_wr_i,
  input logic                reg_rd_i,
  input logic [ADDR_W-1:0]   reg_addr_i,
  input logic [DATA_W-1:0]   reg_wdata_i,
  input logic [2*DATA_W-1:0] time_o,
  input logic [DATA_W-1:0]   inc_q,
  input logic [DATA_W-1:0]   shadow_q,
  input logic [2*DATA_W-1:0] inc_eff
);
  logic time_wr;
  assign time_wr = reg_wr_i && (reg_addr_i == 2'd0 || reg_addr_i == 2'd1);

  p_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !time_wr |=> time_o == $past(time_o) + $past(inc_eff));

  p_wide_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !narrow_mode_i |-> inc_eff < 64'h8000_0000);

  p_narrow_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (narrow_mode_i && inc_q[31:24] != 8'd1 && !time_wr) |=> $stable(time_o));

  p_shadow_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == 2'd0) |=> shadow_q == $past(time_o[63:32]));

  p_load_lo_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd0) |=>
      (time_o[31:0] == $past(reg_wdata_i) && time_o[63:32] == $past(time_o[63:32])));

  p_load_hi_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd1) |=>
      (time_o[63:32] == $past(reg_wdata_i) && time_o[31:0] == $past(time_o[31:0])));

  p_inc_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 2'd2) |=> inc_q == $past(reg_wdata_i));

  p_inc_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_wr_i && reg_addr_i == 2'd2) |=> $stable(inc_q));
endmodule

bind systime_accum systime_accum_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .narrow_mode_i (narrow_mode_i),
  .reg_wr_i      (reg_wr_i),
  .reg_rd_i      (reg_rd_i),
  .reg_addr_i    (reg_addr_i),
  .reg_wdata_i   (reg_wdata_i),
  .time_o        (time_o),
  .inc_q         (inc_q),
  .shadow_q      (shadow_q),
  .inc_eff       (inc_eff)
);

// File: tb/systime_accum_tb.sv
`timescale 1ns/1ps
module systime_accum_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        narrow_mode = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic [63:0] time_val;

  int n_cmp = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  systime_accum dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .narrow_mode_i (narrow_mode),
    .reg_wr_i      (reg_wr),
    .reg_rd_i      (reg_rd),
    .reg_addr_i    (reg_addr),
    .reg_wdata_i   (reg_wdata),
    .reg_rdata_o   (reg_rdata),
    .time_o        (time_val)
  );

  typedef struct packed {
    logic        mode;
    logic [31:0] inc;
    logic [31:0] lo;
    logic [31:0] hi;
    logic [7:0]  n;
    logic [31:0] exp_lo;
    logic [31:0] exp_hi;
  } vec_t;

  localparam vec_t VECS [0:6] = '{
    '{1'b0, 32'h6666_6666, 32'h0000_0000, 32'h0000_0000, 8'd4, 32'h9999_9998, 32'h0000_0001}, // R2 R9
    '{1'b0, 32'hC000_0001, 32'h0000_0000, 32'h0000_0000, 8'd2, 32'h8000_0002, 32'h0000_0000}, // R3
    '{1'b1, 32'h01CC_CCCC, 32'h0000_0000, 32'h0000_0000, 8'd3, 32'h0266_6664, 32'h0000_0000}, // R4
    '{1'b1, 32'h00CC_CCCC, 32'h1234_5678, 32'h0000_0009, 8'd5, 32'h1234_5678, 32'h0000_0009}, // R4
    '{1'b1, 32'h0200_0010, 32'h0000_0005, 32'h0000_0000, 8'd3, 32'h0000_0005, 32'h0000_0000}, // R4
    '{1'b0, 32'h0000_0010, 32'hFFFF_FFF8, 32'hFFFF_FFFF, 8'd1, 32'h0000_0008, 32'h0000_0000}, // R9
    '{1'b0, 32'h0000_0100, 32'hFFFF_FF80, 32'h0000_0007, 8'd1, 32'h0000_0080, 32'h0000_0008}  // R9
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive on the falling edge, then settle before sampling
  task automatic step(input logic wr, input logic rd, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    #1;
  endtask

  task automatic load_time(input logic [31:0] inc, input logic [31:0] lo, input logic [31:0] hi);
    step(1'b1, 1'b0, 2'd2, inc);
    step(1'b1, 1'b0, 2'd0, lo);
    step(1'b1, 1'b0, 2'd1, hi);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: cleared state and no drift
    step(1'b0, 1'b1, 2'd2, 32'd0);
    check("R1 inc after reset", {32'd0, reg_rdata}, 64'd0);
    check("R1 time after reset", time_val, 64'd0);
    step(1'b0, 1'b0, 2'd0, 32'd0);
    step(1'b0, 1'b0, 2'd0, 32'd0);
    check("R1 time holds with zero inc", time_val, 64'd0);

    // table walk: R2 R3 R4 R9
    foreach (VECS[i]) begin
      narrow_mode = VECS[i].mode;
      load_time(VECS[i].inc, VECS[i].lo, VECS[i].hi);
      step(1'b0, 1'b0, 2'd0, 32'd0);
      check($sformatf("R7 vec%0d loaded", i), time_val, {VECS[i].hi, VECS[i].lo});
      for (int k = 0; k < int'(VECS[i].n) - 1; k++) step(1'b0, 1'b0, 2'd0, 32'd0);
      step(1'b0, 1'b1, 2'd0, 32'd0);
      check($sformatf("R2 vec%0d time", i), time_val, {VECS[i].exp_hi, VECS[i].exp_lo});
      check($sformatf("R5 vec%0d low read", i), {32'd0, reg_rdata}, {32'd0, VECS[i].exp_lo});
      step(1'b0, 1'b1, 2'd1, 32'd0);
      check($sformatf("R6 vec%0d high read", i), {32'd0, reg_rdata}, {32'd0, VECS[i].exp_hi});
    end

    // R6: carry between the two halves of a read pair
    narrow_mode = 1'b0;
    load_time(32'h10, 32'hFFFF_FFF0, 32'h5);
    step(1'b0, 1'b1, 2'd0, 32'd0);
    check("R6 low before carry", {32'd0, reg_rdata}, 64'hFFFF_FFF0);
    step(1'b0, 1'b1, 2'd1, 32'd0);
    check("R6 shadow keeps old high", {32'd0, reg_rdata}, 64'h5);
    check("R6 live high carried", time_val, 64'h6_0000_0000);

    // R7: single-word loads suppress the tick
    load_time(32'h100, 32'h0, 32'h0);
    step(1'b0, 1'b0, 2'd0, 32'd0);
    step(1'b0, 1'b0, 2'd0, 32'd0);
    step(1'b1, 1'b0, 2'd0, 32'hABC);
    check("R7 before low load", time_val, 64'h200);
    step(1'b0, 1'b0, 2'd0, 32'd0);
    check("R7 low load exact", time_val, 64'hABC);
    step(1'b1, 1'b0, 2'd1, 32'h22);
    check("R7 resume after load", time_val, 64'hBBC);
    // R8: old increment in the write cycle, new one after
    step(1'b1, 1'b0, 2'd2, 32'h1000);
    check("R7 high load keeps low", time_val, 64'h22_0000_0BBC);
    step(1'b0, 1'b0, 2'd0, 32'd0);
    check("R8 old inc in write cycle", time_val, 64'h22_0000_0CBC);
    // R5: reserved address
    step(1'b1, 1'b1, 2'd3, 32'hFFFF_FFFF);
    check("R8 new inc applied", time_val, 64'h22_0000_1CBC);
    check("R5 reserved reads zero", {32'd0, reg_rdata}, 64'd0);
    step(1'b0, 1'b1, 2'd2, 32'd0);
    check("R5 reserved write ignored inc", {32'd0, reg_rdata}, 64'h1000);
    check("R5 reserved write ignored time", time_val, 64'h22_0000_2CBC);

    // R10: mode switch takes effect in the same cycle
    narrow_mode = 1'b1;
    load_time(32'h0100_0040, 32'h0, 32'h0);
    step(1'b0, 1'b0, 2'd0, 32'd0);
    check("R10 loaded", time_val, 64'h0);
    step(1'b0, 1'b0, 2'd0, 32'd0);
    check("R4 narrow field", time_val, 64'h40);
    narrow_mode = 1'b0;
    step(1'b0, 1'b0, 2'd0, 32'd0);
    check("R10 wide after switch", time_val, 64'h0100_0080);

    // R1: asynchronous reset in mid-count
    #1 rst_ni = 1'b0;
    #1;
    check("R1 async clear time", time_val, 64'd0);
    step(1'b0, 1'b0, 2'd2, 32'd0);
    check("R1 async clear inc", {32'd0, reg_rdata}, 64'd0);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  end
endmodule